// File: doc/BRIEF.md
# Compressed Program-Counter Trace Encoder

This block watches the instruction stream of a processor core and records the program counter (PC) of every executed opcode, legal or illegal, as 20-bit rows for a trace memory. A row is two information bits plus an 18-bit payload. Consecutive opcodes that stay inside one 64-byte region are compressed. Only their 6-bit offsets within the region are kept, and three of them are packed into one payload. When execution moves into another region, the encoder writes the complete 18-bit PC, so that software can rebuild the flow later.

The core pulses `exec_vld` with `exec_pc` once per executed opcode. `trace_en` opens and closes a trace session. The encoder emits at most one registered row per clock on `row_wr`, `row_info` and `row_data`. Offsets still waiting in a partly packed row are written out before any full-PC row, so rows always appear in execution order. A session that ends with offsets still pending closes with a flush row, marked by `row_flush`.

The controller has three states:
- `ST_IDLE` means no region is known yet.
- `ST_TRACK` means a region is known and 0 to 2 offsets are pending.
- `ST_HOLD` means a full-PC row is waiting to be written after a partial row went out.

The transitions are:
- *start*: `ST_IDLE` to `ST_TRACK`, on the first opcode while enabled.
- *pack*: `ST_TRACK` to `ST_TRACK`, on an opcode in the same region or on a crossing with nothing pending.
- *split*: `ST_TRACK` to `ST_HOLD`, on a crossing with offsets pending.
- *resume*: `ST_HOLD` to `ST_TRACK`, when the held row is written and no further crossing occurs.
- *rehold*: `ST_HOLD` to `ST_HOLD`, when another crossing arrives while a row is held.
- *stop*: `ST_TRACK` or `ST_HOLD` to `ST_IDLE`, when `trace_en` drops.

Top module: `pctrc_enc`

## Requirements
- R1: While reset is applied, and after it is released, `row_wr` is low until an opcode is traced.
- R2: The first opcode executed with `trace_en` high after reset, or after a period with `trace_en` low, produces a full-PC row in the following cycle. That row has `row_info` = 2'b11 and `row_data` = the PC, even when the PC lies in the region that was traced last.
- R3: Opcodes in the current 64-byte region (same `exec_pc[17:6]`) have their offsets `exec_pc[5:0]` packed into the payload in order of arrival. The first offset goes to bits [5:0], the second to [11:6] and the third to [17:12]. The third offset completes the row, which is written in the next cycle with `row_info` = 2'b00.
- R4: An opcode outside the current region with no offsets pending produces a full-PC row (`row_info` = 2'b11) in the next cycle.
- R5: An opcode outside the current region with 1 or 2 offsets pending first produces a partial row in the next cycle. That row has `row_info` = 2'b01 for one offset or 2'b10 for two, and unused payload bits are zero. The full-PC row of the new opcode follows one cycle later.
- R6: An opcode that arrives in the cycle a held full-PC row is written is handled against the held PC's region. If it is in that region, its offset becomes the first slot of a new row. If it is not, its own full-PC row follows in the next cycle.
- R7: A cycle with `exec_vld` low adds nothing and writes no row unless a held row or a flush is due.
- R8: When `trace_en` drops with offsets pending, the partial row is written in the next cycle with `row_flush` high. Every other row has `row_flush` low. Opcodes presented while `trace_en` is low write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Trace session enable |
| exec_vld | input | 1 | One executed opcode this cycle |
| exec_pc | input | 18 | PC of the executed opcode |
| row_wr | output | 1 | Row write strobe |
| row_info | output | 2 | 00 three offsets, 01 one offset, 10 two offsets, 11 full PC |
| row_data | output | 18 | Packed offsets or full PC |
| row_flush | output | 1 | Row is the partial row written when tracing stopped |

## Verification
The bench tries a straight run of three opcodes in one region, with an idle cycle between them. This separates correct slot placement and the packed code from leaks of stale offsets. Region crossings are driven with zero, one and two offsets pending, which shows whether partial rows come before full-PC rows and carry the right count code. Crossings that land exactly on the cycle a held row is written, once into the held region and once out of it, exercise the `ST_HOLD` paths. Finally, a disable with an offset pending followed by a re-enable in the same region tells a correct flush and restart apart from reuse of the old region.

// File: rtl/pctrc_pkg.sv
package pctrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRACK,
        ST_HOLD
    } pctrc_state_e;

    typedef enum logic [1:0] {
        ACC_KEEP,
        ACC_ADD,
        ACC_CLR
    } acc_op_e;

    localparam logic [1:0] INFO_PACKED = 2'b00;
    localparam logic [1:0] INFO_ONE    = 2'b01;
    localparam logic [1:0] INFO_TWO    = 2'b10;
    localparam logic [1:0] INFO_FULL   = 2'b11;

endpackage

// File: rtl/pctrc_acc.sv
module pctrc_acc
    import pctrc_pkg::*;
#(
    parameter int OFF_W = 6,
    parameter int SLOTS = 3,
    parameter int CNT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  acc_op_e                op,
    input  logic [OFF_W-1:0]       off,
    output logic [CNT_W-1:0]       count,
    output logic [SLOTS*OFF_W-1:0] cur,
    output logic [SLOTS*OFF_W-1:0] merged
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (op == ACC_CLR) begin
            count <= '0;
        end else if (op == ACC_ADD) begin
            count <= count + 1'b1;
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [OFF_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (op == ACC_CLR) begin
                q <= '0;
            end else if (op == ACC_ADD && count == CNT_W'(s)) begin
                q <= off;
            end
        end

        assign cur[s*OFF_W +: OFF_W]    = q;
        assign merged[s*OFF_W +: OFF_W] = (count == CNT_W'(s)) ? off : q;
    end

endmodule

// File: rtl/pctrc_ctl.sv
module pctrc_ctl
    import pctrc_pkg::*;
#(
    parameter int PC_W  = 18,
    parameter int OFF_W = 6,
    parameter int SLOTS = 3,
    parameter int CNT_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   trace_en,
    input  logic                   exec_vld,
    input  logic [PC_W-1:0]        exec_pc,
    input  logic [CNT_W-1:0]       acc_cnt,
    input  logic [SLOTS*OFF_W-1:0] acc_cur,
    input  logic [SLOTS*OFF_W-1:0] acc_merged,
    output acc_op_e                acc_op,
    output logic                   row_wr,
    output logic [1:0]             row_info,
    output logic [PC_W-1:0]        row_data,
    output logic                   row_flush
);

    localparam int REG_W = PC_W - OFF_W;

    pctrc_state_e    state_q, state_d;
    logic [REG_W-1:0] region_q, region_d;
    logic [PC_W-1:0]  hold_q, hold_d;

    logic            e_wr, e_flush;
    logic [1:0]      e_info;
    logic [PC_W-1:0] e_data;
    logic            same_trk, same_hold;
    logic [1:0]      part_info;

    assign same_trk  = exec_pc[PC_W-1:OFF_W] == region_q;
    assign same_hold = exec_pc[PC_W-1:OFF_W] == hold_q[PC_W-1:OFF_W];
    assign part_info = (acc_cnt == CNT_W'(1)) ? INFO_ONE : INFO_TWO;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            region_q <= '0;
            hold_q   <= '0;
        end else begin
            state_q  <= state_d;
            region_q <= region_d;
            hold_q   <= hold_d;
        end
    end

    // transitions and row decision
    always_comb begin
        state_d  = state_q;
        region_d = region_q;
        hold_d   = hold_q;
        acc_op   = ACC_KEEP;
        e_wr     = 1'b0;
        e_info   = INFO_FULL;
        e_data   = exec_pc;
        e_flush  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (trace_en && exec_vld) begin
                    // start
                    e_wr     = 1'b1;
                    region_d = exec_pc[PC_W-1:OFF_W];
                    state_d  = ST_TRACK;
                end
            end
            ST_TRACK: begin
                if (!trace_en) begin
                    // stop
                    if (acc_cnt != '0) begin
                        e_wr    = 1'b1;
                        e_info  = part_info;
                        e_data  = acc_cur;
                        e_flush = 1'b1;
                    end
                    acc_op  = ACC_CLR;
                    state_d = ST_IDLE;
                end else if (exec_vld) begin
                    if (same_trk) begin
                        // pack
                        if (acc_cnt == CNT_W'(SLOTS-1)) begin
                            e_wr   = 1'b1;
                            e_info = INFO_PACKED;
                            e_data = acc_merged;
                            acc_op = ACC_CLR;
                        end else begin
                            acc_op = ACC_ADD;
                        end
                    end else if (acc_cnt == '0) begin
                        // pack (crossing, nothing pending)
                        e_wr     = 1'b1;
                        region_d = exec_pc[PC_W-1:OFF_W];
                    end else begin
                        // split
                        e_wr    = 1'b1;
                        e_info  = part_info;
                        e_data  = acc_cur;
                        acc_op  = ACC_CLR;
                        hold_d  = exec_pc;
                        state_d = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                e_wr     = 1'b1;
                e_data   = hold_q;
                region_d = hold_q[PC_W-1:OFF_W];
                if (!trace_en) begin
                    // stop
                    state_d = ST_IDLE;
                end else if (exec_vld && !same_hold) begin
                    // rehold
                    hold_d = exec_pc;
                end else begin
                    // resume
                    if (exec_vld) begin
                        acc_op = ACC_ADD;
                    end
                    state_d = ST_TRACK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered row outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_wr    <= 1'b0;
            row_info  <= INFO_PACKED;
            row_data  <= '0;
            row_flush <= 1'b0;
        end else begin
            row_wr    <= e_wr;
            row_info  <= e_wr ? e_info : INFO_PACKED;
            row_data  <= e_wr ? e_data : '0;
            row_flush <= e_wr & e_flush;
        end
    end

endmodule

// File: rtl/pctrc_enc.sv
module pctrc_enc
    import pctrc_pkg::*;
#(
    parameter int PC_W  = 18,
    parameter int OFF_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trace_en,
    input  logic            exec_vld,
    input  logic [PC_W-1:0] exec_pc,
    output logic            row_wr,
    output logic [1:0]      row_info,
    output logic [PC_W-1:0] row_data,
    output logic            row_flush
);

    localparam int SLOTS = PC_W / OFF_W;
    localparam int CNT_W = $clog2(SLOTS + 1);

    acc_op_e                acc_op;
    logic [CNT_W-1:0]       acc_cnt;
    logic [SLOTS*OFF_W-1:0] acc_cur;
    logic [SLOTS*OFF_W-1:0] acc_merged;

    pctrc_acc #(
        .OFF_W(OFF_W),
        .SLOTS(SLOTS),
        .CNT_W(CNT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (acc_op),
        .off   (exec_pc[OFF_W-1:0]),
        .count (acc_cnt),
        .cur   (acc_cur),
        .merged(acc_merged)
    );

    pctrc_ctl #(
        .PC_W (PC_W),
        .OFF_W(OFF_W),
        .SLOTS(SLOTS),
        .CNT_W(CNT_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trace_en  (trace_en),
        .exec_vld  (exec_vld),
        .exec_pc   (exec_pc),
        .acc_cnt   (acc_cnt),
        .acc_cur   (acc_cur),
        .acc_merged(acc_merged),
        .acc_op    (acc_op),
        .row_wr    (row_wr),
        .row_info  (row_info),
        .row_data  (row_data),
        .row_flush (row_flush)
    );

endmodule

// File: rtl/pctrc_chk.sv
module pctrc_chk #(
    parameter int PC_W  = 18,
    parameter int OFF_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trace_en,
    input logic            exec_vld,
    input logic [PC_W-1:0] exec_pc,
    input logic            row_wr,
    input logic [1:0]      row_info,
    input logic [PC_W-1:0] row_data,
    input logic            row_flush
);

    // R3: a completed three-offset row always follows an executed opcode
    a_r3_pack_follows_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wr && row_info == 2'b00) |-> $past(exec_vld && trace_en));

    // R5: a non-flush partial row is followed by a full-PC row
    a_r5_full_follows_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wr && !row_flush && (row_info == 2'b01 || row_info == 2'b10))
        |=> (row_wr && row_info == 2'b11));

    // R5: a single-offset row leaves the upper slots zero
    a_r5_unused_slots_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wr && row_info == 2'b01) |-> (row_data[PC_W-1:OFF_W] == '0));

    // R8: only partial rows carry the flush mark
    a_r8_flush_is_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (row_wr && row_flush) |-> (row_info == 2'b01 || row_info == 2'b10));

    // R8: two disabled cycles in a row leave the row port silent
    a_r8_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(trace_en) && !$past(trace_en, 2)) |-> !row_wr);

endmodule

bind pctrc_enc pctrc_chk #(
    .PC_W (PC_W),
    .OFF_W(OFF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trace_en (trace_en),
    .exec_vld (exec_vld),
    .exec_pc  (exec_pc),
    .row_wr   (row_wr),
    .row_info (row_info),
    .row_data (row_data),
    .row_flush(row_flush)
);

// File: tb/pctrc_enc_test.sv
module pctrc_enc_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        exec_vld = 1'b0;
    logic [17:0] exec_pc = '0;
    logic        row_wr;
    logic [1:0]  row_info;
    logic [17:0] row_data;
    logic        row_flush;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pctrc_enc uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .trace_en (trace_en),
        .exec_vld (exec_vld),
        .exec_pc  (exec_pc),
        .row_wr   (row_wr),
        .row_info (row_info),
        .row_data (row_data),
        .row_flush(row_flush)
    );

    task automatic expect_row(input string tag, input logic ew, input logic [1:0] ei,
                              input logic [17:0] ed, input logic ef);
        total++;
        if (row_wr !== ew || (ew && (row_info !== ei || row_data !== ed || row_flush !== ef))) begin
            bad++;
            $display("FAIL %s: got wr=%0b info=%b data=%h flush=%0b, expected wr=%0b info=%b data=%h flush=%0b",
                     tag, row_wr, row_info, row_data, row_flush, ew, ei, ed, ef);
        end
    endtask

    task automatic step(input logic en, input logic vld, input logic [17:0] pc, input string tag,
                        input logic ew, input logic [1:0] ei, input logic [17:0] ed, input logic ef);
        trace_en = en;
        exec_vld = vld;
        exec_pc  = pc;
        @(posedge clk);
        #1;
        expect_row(tag, ew, ei, ed, ef);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_row("R1 in reset", 1'b0, 2'b00, 18'h0, 1'b0);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 18'h0, "R1 after release", 1'b0, 2'b00, 18'h0, 1'b0);
    endtask

    task automatic t_first();
        step(1'b1, 1'b1, 18'h01234, "R2 first opcode full row", 1'b1, 2'b11, 18'h01234, 1'b0);
    endtask

    task automatic t_pack();
        step(1'b1, 1'b1, 18'h01205, "R3 slot0 held", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b0, 18'h3FFFF, "R7 idle cycle", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h0121A, "R3 slot1 held", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h0123F, "R3 packed row", 1'b1, 2'b00, {6'h3F, 6'h1A, 6'h05}, 1'b0);
    endtask

    task automatic t_cross_empty();
        step(1'b1, 1'b1, 18'h00040, "R4 crossing empty", 1'b1, 2'b11, 18'h00040, 1'b0);
    endtask

    task automatic t_cross_partial();
        step(1'b1, 1'b1, 18'h00041, "R5 first offset", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h00050, "R5 second offset", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h2ABC0, "R5 two-offset partial", 1'b1, 2'b10, {6'h00, 6'h10, 6'h01}, 1'b0);
        step(1'b1, 1'b0, 18'h0, "R5 full after partial", 1'b1, 2'b11, 18'h2ABC0, 1'b0);
        step(1'b1, 1'b1, 18'h2ABC7, "R5 one offset", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h00000, "R5 one-offset partial", 1'b1, 2'b01, 18'h00007, 1'b0);
    endtask

    task automatic t_hold();
        step(1'b1, 1'b1, 18'h00003, "R6 same region during hold", 1'b1, 2'b11, 18'h00000, 1'b0);
        step(1'b1, 1'b1, 18'h3FFC0, "R6 offset kept as slot0", 1'b1, 2'b01, 18'h00003, 1'b0);
        step(1'b1, 1'b1, 18'h12345, "R6 crossing during hold", 1'b1, 2'b11, 18'h3FFC0, 1'b0);
        step(1'b1, 1'b0, 18'h0, "R6 second full row", 1'b1, 2'b11, 18'h12345, 1'b0);
    endtask

    task automatic t_disable();
        step(1'b1, 1'b1, 18'h12352, "R8 pending offset", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b0, 1'b1, 18'h20000, "R8 flush row", 1'b1, 2'b01, 18'h00012, 1'b1);
        step(1'b0, 1'b1, 18'h20000, "R8 disabled opcode ignored", 1'b0, 2'b00, 18'h0, 1'b0);
        step(1'b1, 1'b1, 18'h12353, "R2 restart same region full", 1'b1, 2'b11, 18'h12353, 1'b0);
    endtask

    initial begin
        t_reset();
        t_first();
        t_pack();
        t_cross_empty();
        t_cross_partial();
        t_hold();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no end, expected end of run");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule